// File: doc/BRIEF.md
# Batched-Entry Delay Queue

This block is a synchronous queue. In one clock cycle it can accept a batch of up to `P` values, and it releases at most one value per cycle. A producer presents the batch as a small array together with an element count. The element at index 0 is queued first, and higher indices follow in order behind it. The consumer sees a data word with a present flag. That flag comes only from registered state, so a value is never visible in the same cycle in which it is offered.

Storage is a circular buffer of `DEPTH` words with head and tail pointers and an occupancy counter. When the queue holds anything at a clock edge, the head word leaves at that edge, because it was shown on the output during the cycle. In the same edge the new batch lands behind the remaining words. When the queue is empty at an edge, nothing leaves and the batch simply becomes the contents. The capacity is bounded. A batch that would not fit after the pop loses its trailing elements, and a one-cycle overflow flag reports the loss. There is no backpressure in either direction.

Top module: `batch_fifo`

## Requirements
- R1: `rst` is synchronous and active high. On the cycle after an edge where `rst` is 1, the queue is empty, `out_valid` is 0 and `overflow` is 0.
- R2: On each edge, the first `min(in_count, P)` elements of `in_data` are taken in index order, with index 0 first. A count above `P` acts as `P`.
- R3: `out_valid` is 1 exactly when the queue holds at least one word, and `out_data` is then the oldest stored word. Both outputs depend on registered state only.
- R4: A value offered before an edge is not visible on the outputs before that edge. Changing the inputs between edges leaves the outputs unchanged.
- R5: If the queue is empty at an edge, no word is removed and the accepted batch becomes the whole contents.
- R6: If the queue is non-empty at an edge, exactly one word, the head, is removed, and the accepted batch is placed behind the remaining words.
- R7: The queue never holds more than `DEPTH` words. Free room is counted after the pop. Batch elements beyond the room are dropped, and the leading ones are kept.
- R8: `overflow` is 1 for the cycle after an edge at which at least one element was dropped. Otherwise it is 0.
- R9: Word order is preserved when storage wraps past its last slot.
- R10: With `in_count` = 0, an edge only pops the head and reorders nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | P*DW | Batch elements; index 0 is queued first |
| in_count | input | $clog2(P+1) | Number of valid batch elements (values above P act as P) |
| out_data | output | DW | Head word of the queue |
| out_valid | output | 1 | High when the queue is non-empty |
| overflow | output | 1 | One-cycle pulse after elements were dropped |

## Verification
A table of batches is driven through the queue. It covers single pushes into an empty queue, mixed batch sizes into a partly filled queue, idle cycles that only drain, and oversized counts. Together these separate the empty-queue rule from the pop-and-append rule and show whether index order survives wraparound. Back-to-back full batches push the queue against its capacity. They show whether room is counted after the pop, and that the overflow pulse falls again once a cycle drops nothing. Before every edge the bench changes the inputs and confirms the outputs do not move, so any path from input to output shows up. A reset issued while the queue is full must leave it empty.

// File: rtl/batch_fifo_pkg.sv
package batch_fifo_pkg;

    // Add an offset to a ring index and fold it back into [0, depth).
    function automatic int unsigned ring_add(int unsigned base,
                                             int unsigned off,
                                             int unsigned depth);
        int unsigned sum;
        sum = base + off;
        if (sum >= depth) begin
            sum = sum - depth;
        end
        return sum;
    endfunction

    function automatic int unsigned min_u(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/batch_fifo_admit.sv
module batch_fifo_admit #(
    parameter int P     = 4,
    parameter int DEPTH = 8,
    parameter int CNTW  = 4,
    parameter int INW   = 3
) (
    input  logic [CNTW-1:0] occ,
    input  logic [INW-1:0]  req_count,
    output logic            pop,
    output logic [INW-1:0]  take_count,
    output logic            drop
);
    import batch_fifo_pkg::*;

    int unsigned req_n;
    int unsigned after_pop;
    int unsigned room;
    int unsigned take_n;

    always_comb begin
        pop       = (occ != '0);
        req_n     = min_u(int'(req_count), P);
        after_pop = int'(occ) - (pop ? 1 : 0);
        room      = DEPTH - after_pop;
        take_n    = min_u(req_n, room);
        drop      = (req_n > room);
        take_count = INW'(take_n);
    end

endmodule

// File: rtl/batch_fifo_ring.sv
module batch_fifo_ring #(
    parameter int DW    = 8,
    parameter int P     = 4,
    parameter int DEPTH = 8,
    parameter int PTRW  = 3,
    parameter int INW   = 3
) (
    input  logic                 clk,
    input  logic [PTRW-1:0]      wr_base,
    input  logic [INW-1:0]       wr_num,
    input  logic [P-1:0][DW-1:0] wr_data,
    input  logic [PTRW-1:0]      rd_ptr,
    output logic [DW-1:0]        rd_data
);
    import batch_fifo_pkg::*;

    logic [DW-1:0] slot_view [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        logic [DW-1:0] cell_d;
        logic [DW-1:0] cell_q;

        always_comb begin
            cell_d = cell_q;
            for (int i = 0; i < P; i++) begin
                if ((i < int'(wr_num)) &&
                    (ring_add(int'(wr_base), i, DEPTH) == j)) begin
                    cell_d = wr_data[i];
                end
            end
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign slot_view[j] = cell_q;
    end

    assign rd_data = slot_view[rd_ptr];

endmodule

// File: rtl/batch_fifo.sv
module batch_fifo #(
    parameter int DW    = 8,
    parameter int P     = 4,
    parameter int DEPTH = 8,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int INW  = $clog2(P + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [P-1:0][DW-1:0] in_data,
    input  logic [INW-1:0]       in_count,
    output logic [DW-1:0]        out_data,
    output logic                 out_valid,
    output logic                 overflow
);
    import batch_fifo_pkg::*;

    typedef struct packed {
        logic [PTRW-1:0] head;
        logic [PTRW-1:0] tail;
        logic [CNTW-1:0] occ;
        logic            ovf;
    } state_t;

    state_t         st_d;
    state_t         st_q;
    logic           pop;
    logic [INW-1:0] take_count;
    logic           drop;
    logic [DW-1:0]  head_word;

    batch_fifo_admit #(
        .P(P), .DEPTH(DEPTH), .CNTW(CNTW), .INW(INW)
    ) u_admit (
        .occ        (st_q.occ),
        .req_count  (in_count),
        .pop        (pop),
        .take_count (take_count),
        .drop       (drop)
    );

    batch_fifo_ring #(
        .DW(DW), .P(P), .DEPTH(DEPTH), .PTRW(PTRW), .INW(INW)
    ) u_ring (
        .clk     (clk),
        .wr_base (st_q.tail),
        .wr_num  (take_count),
        .wr_data (in_data),
        .rd_ptr  (st_q.head),
        .rd_data (head_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.head = PTRW'(ring_add(int'(st_q.head), pop ? 1 : 0, DEPTH));
        st_d.tail = PTRW'(ring_add(int'(st_q.tail), int'(take_count), DEPTH));
        st_d.occ  = CNTW'(int'(st_q.occ) - (pop ? 1 : 0) + int'(take_count));
        st_d.ovf  = drop;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = (st_q.occ != '0);
    assign out_data  = head_word;
    assign overflow  = st_q.ovf;

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !overflow)); // R1

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.occ <= CNTW'(DEPTH)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (st_q.occ == CNTW'(DEPTH))); // R7

    AST_SINGLE_POP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(out_valid) && ($past(in_count) == '0))
        |-> (st_q.occ == CNTW'(int'($past(st_q.occ)) - 1))); // R6

    AST_EMPTY_KEEPS_BATCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(out_valid) && ($past(in_count) != '0) &&
         (int'($past(in_count)) <= P) && (P <= DEPTH))
        |-> (st_q.occ == CNTW'($past(in_count)))); // R5

endmodule

// File: tb/batch_fifo_bench.sv
`timescale 1ns/1ps
module batch_fifo_bench;
    localparam int DW = 8;
    localparam int P = 4;
    localparam int DEPTH = 8;
    localparam int INW = $clog2(P + 1);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [P-1:0][DW-1:0] in_data = '0;
    logic [INW-1:0]       in_count = '0;
    logic [DW-1:0]        out_data;
    logic                 out_valid;
    logic                 overflow;

    always #2.5 clk = ~clk;

    batch_fifo #(.DW(DW), .P(P), .DEPTH(DEPTH)) u_batch_fifo (
        .clk(clk), .rst(rst), .in_data(in_data), .in_count(in_count),
        .out_data(out_data), .out_valid(out_valid), .overflow(overflow)
    );

    int checks = 0;
    int failures = 0;
    int unsigned model_q[$];
    bit model_ovf = 1'b0;
    bit model_known = 1'b0;

    typedef struct packed {
        logic [7:0]  tag;
        logic [2:0]  cnt;
        logic [31:0] d;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{8'd5,  3'd1, 32'h0000_0011}, // R5 single push into empty queue
        '{8'd10, 3'd0, 32'hAAAA_AAAA}, // R10 idle cycle only pops
        '{8'd2,  3'd3, 32'h0023_2221}, // R2 three in index order
        '{8'd6,  3'd2, 32'h0000_3231}, // R6 pop plus append
        '{8'd6,  3'd4, 32'h4443_4241}, // R6 full batch
        '{8'd7,  3'd4, 32'h5453_5251}, // R7 batch exceeds room
        '{8'd8,  3'd0, 32'h0000_0000}, // R8 pulse drops again
        '{8'd2,  3'd7, 32'h6463_6261}, // R2 count above P saturates
        '{8'd10, 3'd0, 32'h0000_0000}, // R10
        '{8'd3,  3'd1, 32'h0000_0071}, // R3
        '{8'd9,  3'd4, 32'h8483_8281}, // R9 wraps storage
        '{8'd9,  3'd3, 32'h0093_9291}, // R9
        '{8'd6,  3'd0, 32'h0000_0000}, // R6 drain
        '{8'd6,  3'd0, 32'h0000_0000},
        '{8'd9,  3'd2, 32'h0000_A2A1}, // R9
        '{8'd10, 3'd0, 32'h0000_0000}  // R10
    };

    task automatic check_outputs(string tag);
        bit exp_valid;
        int unsigned exp_data;
        exp_valid = (model_q.size() > 0);
        exp_data  = exp_valid ? model_q[0] : 0;
        checks++;
        if (out_valid !== exp_valid || overflow !== model_ovf ||
            (exp_valid && out_data !== DW'(exp_data))) begin
            failures++;
            $display("FAIL %s: valid=%0b data=%0h ovf=%0b expected valid=%0b data=%0h ovf=%0b",
                     tag, out_valid, out_data, overflow, exp_valid, exp_data, model_ovf);
        end
    endtask

    task automatic model_edge(bit r, int cnt, logic [31:0] d);
        int n;
        model_ovf = 1'b0;
        if (r) begin
            model_q.delete();
        end else begin
            if (model_q.size() > 0) void'(model_q.pop_front());
            n = (cnt > P) ? P : cnt;
            for (int i = 0; i < n; i++) begin
                if (model_q.size() < DEPTH) model_q.push_back(d[8*i +: 8]);
                else model_ovf = 1'b1;
            end
        end
        model_known = 1'b1;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic do_cycle(bit r, int cnt, logic [31:0] d, string tag);
        rst = r;
        in_count = INW'(cnt);
        in_data = d;
        #1;
        if (model_known) check_outputs("R4 outputs ignore new inputs before edge");
        @(posedge clk);
        #1;
        model_edge(r, cnt, d);
        check_outputs(tag);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_cycle(1'b1, 0, 32'h0, "R1 reset empties queue");
        do_cycle(1'b1, 4, 32'hDEAD_BEEF, "R1 reset ignores batch");

        for (int v = 0; v < NVEC; v++) begin
            do_cycle(1'b0, int'(VECS[v].cnt), VECS[v].d,
                     $sformatf("R%0d table row %0d", VECS[v].tag, v));
        end

        // Fill to capacity and overflow repeatedly: R7, R8
        do_cycle(1'b0, 4, 32'hB4B3_B2B1, "R7 fill");
        do_cycle(1'b0, 4, 32'hC4C3_C2C1, "R7 fill");
        do_cycle(1'b0, 4, 32'hD4D3_D2D1, "R7 drop trailing elements");
        do_cycle(1'b0, 4, 32'hE4E3_E2E1, "R8 overflow stays while dropping");
        do_cycle(1'b0, 1, 32'h0000_00F1, "R8 overflow clears when all fit");

        // Reset while full: R1
        do_cycle(1'b1, 4, 32'h1111_1111, "R1 reset while full");
        do_cycle(1'b0, 0, 32'h0, "R3 empty queue absent");
        do_cycle(1'b0, 1, 32'h0000_0055, "R5 push after reset");
        do_cycle(1'b0, 0, 32'h0, "R3 drains to absent");

        // Long wrap run: R9
        for (int k = 0; k < 12; k++) begin
            do_cycle(1'b0, (k % 3), {8'(k*4+3), 8'(k*4+2), 8'(k*4+1), 8'(k*4)},
                     "R9 wrap order");
        end
        for (int k = 0; k < 10; k++) begin
            do_cycle(1'b0, 0, 32'h0, "R10 idle drain");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule